// File: doc/BRIEF.md
# Serial Port Register Block

This block is the bus-facing register file of a simple serial port. A host reaches four 32-bit registers through a single-cycle access port. The registers are receive data, transmit data, status and control. Incoming bytes from the line side go into an eight-entry receive queue. Each byte written to the transmit register leaves as a one-cycle output strobe. One level interrupt line tells the host that there is work to do.

The bit-level serialiser and deserialiser, the baud generator and frame or parity checking all sit outside this block. The status bits that would report those conditions always read as zero, and the transmit side always reports itself as empty. The interrupt-pending flag is sticky. Buffered receive data sets it, and so does any transmit write. A receive-path reset through the control register clears it.

Top module: `sio_regs`

## Requirements
- R1: The register is selected by byte address bits [3:2]: 0 is receive data, 1 is transmit data, 2 is status and 3 is control. Address bits [1:0] are ignored. For a read, `bus_rdata` is valid combinationally in the cycle the access is presented.
- R2: The status word is laid out as follows:
  - bit0 is the receive count not equal to 0.
  - bit1 is the receive count equal to 8.
  - bit2 is always 1.
  - bit4 is interrupt pending.
  - bits 3, 5, 6, 7 and 31:8 read 0.
- R3: The receive queue keeps up to 8 bytes in arrival order. A read of the receive register returns the oldest byte, zero-extended, and removes it.
- R4: A read of the receive register while the queue is empty returns the byte stored at the location (write pointer minus count) modulo 8. The count does not change.
- R5: `rx_in_ready` is high exactly when the count is below 8. A byte offered while the count is 8 is dropped, and the stored contents do not change.
- R6: A receive-register read and an accepted incoming byte in the same cycle both take effect. The count stays the same and the new byte joins the tail.
- R7: A write to the transmit register raises `tx_out_valid` for exactly the next cycle, with `tx_out_data` set to write data bits [7:0]. A later read of the transmit register returns the full written word.
- R8: Interrupt pending becomes 1 whenever the count after an update is nonzero, and on every transmit write. It stays 1 until it is cleared. `irq` equals pending AND control bit4.
- R9: A control write with bit1 set empties the receive queue: the pointer and the count go to zero. It also clears interrupt pending, and an incoming byte in that same cycle is discarded. Every control write stores the full word, and the stored word reads back. Control bit0 has no effect.
- R10: A write to the status register changes no state. It raises `wr_err` for exactly the next cycle.
- R11: During and after a synchronous active-low reset:
  - the count, pending and control are 0;
  - `irq`, `tx_out_valid` and `wr_err` are 0;
  - status reads 0x00000004.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_sel | input | 1 | Access request, one access per cycle |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 4 | Byte address within the 16-byte block |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational |
| rx_in_valid | input | 1 | Incoming byte offered |
| rx_in_data | input | 8 | Incoming byte |
| rx_in_ready | output | 1 | Queue can accept a byte (count below 8) |
| tx_out_valid | output | 1 | One-cycle strobe for an outgoing byte |
| tx_out_data | output | 8 | Outgoing byte |
| irq | output | 1 | Level interrupt |
| wr_err | output | 1 | One-cycle flag for a rejected status write |

## Verification
The hardest cases to reach are the collisions: a host pop landing in the same cycle as a line-side push, and a receive reset landing in the same cycle as a push. A third case is a read of an empty queue that must return a stale byte from a location that has already wrapped. The stimulus first fills the queue past its limit so that every slot holds a known byte and the pointer has wrapped. It then drains the queue completely and reads once more. Directed cycles place pop and push together at a middle count, at zero and at full. A long random phase then mixes reads, writes, resets and pushes on every cycle against the behavioural model.

// File: rtl/sio_regs_pkg.sv
// Package: shared constants for the serial port register block.
// Assumes a 32-bit data bus and a 16-byte register window.
package sio_regs_pkg;
    localparam int unsigned BUS_W   = 32;
    localparam int unsigned BYTE_W  = 8;

    typedef enum logic [1:0] {
        SEL_RXD  = 2'd0,
        SEL_TXD  = 2'd1,
        SEL_STAT = 2'd2,
        SEL_CTRL = 2'd3
    } reg_sel_e;

    // Status bit positions
    localparam int unsigned ST_RX_VALID = 0;
    localparam int unsigned ST_RX_FULL  = 1;
    localparam int unsigned ST_TX_EMPTY = 2;
    localparam int unsigned ST_PENDING  = 4;

    // Control bit positions
    localparam int unsigned CT_RX_CLR   = 1;
    localparam int unsigned CT_IRQ_EN   = 4;
endpackage

// File: rtl/sio_rx_fifo.sv
// Module: receive byte queue, a circular store with a wrapping write pointer
// and an occupancy count; the read slot is (write pointer - count) mod DEPTH.
// Assumes DEPTH is a power of two. Flush has priority over push and pop.
module sio_rx_fifo #(
    parameter int unsigned DEPTH = 8,
    parameter int unsigned DW    = 8,
    localparam int unsigned AW   = $clog2(DEPTH),
    localparam int unsigned CW   = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          push_req,
    input  logic [DW-1:0] push_data,
    input  logic          pop_req,
    input  logic          flush,
    output logic [DW-1:0] head_data,
    output logic [CW-1:0] count,
    output logic [CW-1:0] count_next,
    output logic          has_room
);
    logic [DW-1:0] store [DEPTH];
    logic [AW-1:0] wr_ptr;
    logic [AW-1:0] rd_slot;
    logic          do_push;
    logic          do_pop;

    // Accept and removal qualification
    always_comb begin
        has_room = (count < CW'(DEPTH));
        do_push  = push_req && has_room && !flush;
        do_pop   = pop_req && (count != '0) && !flush;
        rd_slot  = wr_ptr - count[AW-1:0];
        head_data = store[rd_slot];
    end

    // Next occupancy
    always_comb begin
        if (flush)
            count_next = '0;
        else
            count_next = count + CW'(do_push) - CW'(do_pop);
    end

    // Pointer and count registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            count  <= '0;
        end else begin
            count <= count_next;
            if (flush)
                wr_ptr <= '0;
            else if (do_push)
                wr_ptr <= wr_ptr + AW'(1);
        end
    end

    // Byte storage
    generate
        for (genvar i = 0; i < DEPTH; i++) begin : g_slot
            always_ff @(posedge clk) begin
                if (!rst_n)
                    store[i] <= '0;
                else if (do_push && (wr_ptr == AW'(i)))
                    store[i] <= push_data;
            end
        end
    endgenerate

    // R5: occupancy never passes DEPTH
    a_r5_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
        count <= CW'(DEPTH));

    // R5: an offer while full leaves the count at DEPTH
    a_r5_drop_full: assert property (@(posedge clk) disable iff (!rst_n)
        (count == CW'(DEPTH) && push_req && !pop_req && !flush) |=> (count == CW'(DEPTH)));

    // R6: simultaneous accepted push and pop keep the count
    a_r6_swap_stable: assert property (@(posedge clk) disable iff (!rst_n)
        (push_req && pop_req && !flush && count != '0 && count != CW'(DEPTH)) |=> $stable(count));

    // R9: flush empties the queue
    a_r9_flush_empty: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> (count == '0));
endmodule

// File: rtl/sio_ctrl_stat.sv
// Module: control register, sticky interrupt-pending flag, status word and irq.
// Assumes count_after is the queue occupancy after the current cycle's update.
module sio_ctrl_stat
    import sio_regs_pkg::*;
#(
    parameter int unsigned DEPTH = 8,
    localparam int unsigned CW   = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ctrl_wr,
    input  logic             tx_wr,
    input  logic [BUS_W-1:0] wdata,
    input  logic [CW-1:0]    count_now,
    input  logic [CW-1:0]    count_after,
    output logic [BUS_W-1:0] ctrl_q,
    output logic [BUS_W-1:0] status_word,
    output logic             rx_clear,
    output logic             irq
);
    logic pending;

    assign rx_clear = ctrl_wr && wdata[CT_RX_CLR];

    // Control register storage
    always_ff @(posedge clk) begin
        if (!rst_n)
            ctrl_q <= '0;
        else if (ctrl_wr)
            ctrl_q <= wdata;
    end

    // Sticky pending: cleared by receive reset, set by data or transmit write
    always_ff @(posedge clk) begin
        if (!rst_n)
            pending <= 1'b0;
        else if (rx_clear)
            pending <= 1'b0;
        else if (tx_wr || (count_after != '0))
            pending <= 1'b1;
    end

    // Status word assembly from live count and pending
    always_comb begin
        status_word              = '0;
        status_word[ST_RX_VALID] = (count_now != '0);
        status_word[ST_RX_FULL]  = (count_now == CW'(DEPTH));
        status_word[ST_TX_EMPTY] = 1'b1;
        status_word[ST_PENDING]  = pending;
    end

    // Interrupt output
    assign irq = pending && ctrl_q[CT_IRQ_EN];

    // R8: a transmit write leaves pending set
    a_r8_tx_sets_pending: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_wr && !rx_clear) |=> pending);

    // R8: pending is sticky without a receive reset
    a_r8_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (pending && !rx_clear) |=> pending);

    // R9: receive reset clears pending
    a_r9_clear_pending: assert property (@(posedge clk) disable iff (!rst_n)
        rx_clear |=> !pending);
endmodule

// File: rtl/sio_regs.sv
// Module: top of the serial port register block. Decodes single-cycle bus
// accesses, routes pushes and pops into the receive queue, registers the
// transmit strobe and the status-write error flag.
// Assumes one access per cycle; reads return data combinationally.
module sio_regs
    import sio_regs_pkg::*;
#(
    parameter int unsigned DEPTH = 8,
    localparam int unsigned CW   = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_sel,
    input  logic              bus_we,
    input  logic [3:0]        bus_addr,
    input  logic [BUS_W-1:0]  bus_wdata,
    output logic [BUS_W-1:0]  bus_rdata,
    input  logic              rx_in_valid,
    input  logic [BYTE_W-1:0] rx_in_data,
    output logic              rx_in_ready,
    output logic              tx_out_valid,
    output logic [BYTE_W-1:0] tx_out_data,
    output logic              irq,
    output logic              wr_err
);
    reg_sel_e          sel;
    logic              rd_rx, wr_tx, wr_stat, wr_ctrl;
    logic [BUS_W-1:0]  tx_q;
    logic [BUS_W-1:0]  ctrl_q;
    logic [BUS_W-1:0]  status_word;
    logic [BYTE_W-1:0] head_data;
    logic [CW-1:0]     count;
    logic [CW-1:0]     count_next;
    logic              rx_clear;
    logic              unused_addr_lsb;

    assign unused_addr_lsb = ^bus_addr[1:0];

    // Access decode
    always_comb begin
        sel     = reg_sel_e'(bus_addr[3:2]);
        rd_rx   = bus_sel && !bus_we && (sel == SEL_RXD);
        wr_tx   = bus_sel &&  bus_we && (sel == SEL_TXD);
        wr_stat = bus_sel &&  bus_we && (sel == SEL_STAT);
        wr_ctrl = bus_sel &&  bus_we && (sel == SEL_CTRL);
    end

    sio_rx_fifo #(.DEPTH(DEPTH), .DW(BYTE_W)) u_fifo (
        .clk        (clk),
        .rst_n      (rst_n),
        .push_req   (rx_in_valid),
        .push_data  (rx_in_data),
        .pop_req    (rd_rx),
        .flush      (rx_clear),
        .head_data  (head_data),
        .count      (count),
        .count_next (count_next),
        .has_room   (rx_in_ready)
    );

    sio_ctrl_stat #(.DEPTH(DEPTH)) u_cs (
        .clk         (clk),
        .rst_n       (rst_n),
        .ctrl_wr     (wr_ctrl),
        .tx_wr       (wr_tx),
        .wdata       (bus_wdata),
        .count_now   (count),
        .count_after (count_next),
        .ctrl_q      (ctrl_q),
        .status_word (status_word),
        .rx_clear    (rx_clear),
        .irq         (irq)
    );

    // Transmit holding register and outgoing strobe
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tx_q         <= '0;
            tx_out_valid <= 1'b0;
            tx_out_data  <= '0;
        end else begin
            tx_out_valid <= wr_tx;
            if (wr_tx) begin
                tx_q        <= bus_wdata;
                tx_out_data <= bus_wdata[BYTE_W-1:0];
            end
        end
    end

    // Status-write error flag
    always_ff @(posedge clk) begin
        if (!rst_n)
            wr_err <= 1'b0;
        else
            wr_err <= wr_stat;
    end

    // Read data multiplexer
    always_comb begin
        unique case (sel)
            SEL_RXD:  bus_rdata = {{(BUS_W-BYTE_W){1'b0}}, head_data};
            SEL_TXD:  bus_rdata = tx_q;
            SEL_STAT: bus_rdata = status_word;
            default:  bus_rdata = ctrl_q;
        endcase
    end

    // R7: a transmit write strobes the output next cycle
    a_r7_tx_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        wr_tx |=> (tx_out_valid && tx_out_data == $past(bus_wdata[BYTE_W-1:0])));

    // R10: status write flags an error next cycle
    a_r10_err_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        wr_stat |=> wr_err);

    // R10: status write leaves control unchanged
    a_r10_no_ctrl_change: assert property (@(posedge clk) disable iff (!rst_n)
        wr_stat |=> $stable(ctrl_q));

    // R8: interrupt only when enabled
    a_r8_irq_gated: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> ctrl_q[CT_IRQ_EN]);
endmodule

// File: tb/sio_regs_test.sv
// Bench: behavioural reference model compared against the block each cycle.
module sio_regs_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_sel = 1'b0, bus_we = 1'b0;
    logic [3:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        rx_in_valid = 1'b0;
    logic [7:0]  rx_in_data = '0;
    logic        rx_in_ready, tx_out_valid, irq, wr_err;
    logic [7:0]  tx_out_data;

    int checks = 0;
    int failures = 0;
    bit live = 0;
    bit done = 0;

    // reference model state
    int          m_mem [8];
    int          m_wp = 0;
    int          m_cnt = 0;
    bit          m_pend = 0;
    logic [31:0] m_ctrl = '0;
    logic [31:0] m_tx = '0;
    bit          m_txv = 0;
    logic [7:0]  m_txd = '0;
    bit          m_err = 0;

    always #5 clk = ~clk;

    sio_regs uut (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_we(bus_we),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .rx_in_valid(rx_in_valid), .rx_in_data(rx_in_data),
        .rx_in_ready(rx_in_ready), .tx_out_valid(tx_out_valid),
        .tx_out_data(tx_out_data), .irq(irq), .wr_err(wr_err)
    );

    task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic logic [31:0] m_status();
        logic [31:0] s = 32'h4;
        s[0] = (m_cnt != 0);
        s[1] = (m_cnt == 8);
        s[4] = m_pend;
        return s;
    endfunction

    function automatic logic [31:0] m_read(logic [3:0] a);
        case (a[3:2])
            2'd0: return 32'(m_mem[(m_wp - m_cnt + 8) % 8]);
            2'd1: return m_tx;
            2'd2: return m_status();
            default: return m_ctrl;
        endcase
    endfunction

    // one bus cycle with optional incoming byte
    task automatic cyc(bit sel, bit we, logic [3:0] a, logic [31:0] wd,
                       bit rv, logic [7:0] rd, string tag);
        bit pop, push, clr;
        @(negedge clk);
        bus_sel = sel; bus_we = we; bus_addr = a; bus_wdata = wd;
        rx_in_valid = rv; rx_in_data = rd;
        #1;
        if (sel && !we) check({tag, " R1 rdata"}, bus_rdata, m_read(a));
        @(posedge clk);
        #1;
        m_txv = 0; m_err = 0; clr = 0;
        if (sel && we) begin
            case (a[3:2])
                2'd1: begin m_txv = 1; m_txd = wd[7:0]; m_tx = wd; m_pend = 1; end
                2'd2: m_err = 1;
                2'd3: begin m_ctrl = wd; clr = wd[1]; end
                default: ;
            endcase
        end
        pop  = sel && !we && a[3:2] == 2'd0 && m_cnt != 0;
        push = rv && m_cnt < 8;
        if (clr) begin
            m_cnt = 0; m_wp = 0; m_pend = 0;
        end else begin
            if (push) begin m_mem[m_wp] = int'(rd); m_wp = (m_wp + 1) % 8; end
            m_cnt = m_cnt + int'(push) - int'(pop);
            if (m_cnt != 0) m_pend = 1;
        end
    endtask

    task automatic idle(); cyc(0, 0, 4'h0, 0, 0, 8'h0, "idle"); endtask
    task automatic rd(logic [3:0] a, string t); cyc(1, 0, a, 0, 0, 8'h0, t); endtask
    task automatic wr(logic [3:0] a, logic [31:0] d, string t); cyc(1, 1, a, d, 0, 8'h0, t); endtask
    task automatic push(logic [7:0] d, string t); cyc(0, 0, 4'h0, 0, 1, d, t); endtask

    // per-cycle comparison of registered outputs against the model
    always @(negedge clk) begin
        if (live && !done) begin
            check("R5 rx_in_ready", 32'(rx_in_ready), 32'(m_cnt < 8));
            check("R8 irq", 32'(irq), 32'(m_pend && m_ctrl[4]));
            check("R7 tx_out_valid", 32'(tx_out_valid), 32'(m_txv));
            if (m_txv) check("R7 tx_out_data", 32'(tx_out_data), 32'(m_txd));
            check("R10 wr_err", 32'(wr_err), 32'(m_err));
        end
    end

    // watchdog
    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1;
            failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < 8; i++) m_mem[i] = 0;
        repeat (3) @(negedge clk);
        // R11: reset state
        check("R11 irq in reset", 32'(irq), 0);
        check("R11 tx_out_valid in reset", 32'(tx_out_valid), 0);
        check("R11 wr_err in reset", 32'(wr_err), 0);
        bus_sel = 1; bus_we = 0; bus_addr = 4'h8; #1;
        check("R11 status in reset", bus_rdata, 32'h4);
        bus_sel = 0;
        rst_n = 1;
        live = 1;
        rd(4'h8, "R11 status after reset");
        rd(4'hC, "R11 control after reset");
        rd(4'h0, "R4 empty read after reset");

        // R3: FIFO order, with unaligned address bits ignored (R1)
        push(8'hA1, "R3"); push(8'hB2, "R3"); push(8'hC3, "R3");
        rd(4'h8, "R2 status three bytes");
        rd(4'h0, "R3 pop first"); rd(4'h1, "R3 pop second R1"); rd(4'h3, "R3 pop third R1");
        rd(4'h8, "R2 status empty pending");
        rd(4'h0, "R4 empty stale read");

        // R5: fill past capacity, extra byte dropped
        for (int i = 0; i < 9; i++) push(8'(8'h10 + i), "R5 fill");
        rd(4'h8, "R2 status full");
        cyc(1, 0, 4'h0, 0, 1, 8'hEE, "R5 full pop with offer");
        rd(4'h8, "R2 status after pop");
        // R6: simultaneous pop and push at a middle count
        cyc(1, 0, 4'h0, 0, 1, 8'h77, "R6 swap");
        cyc(1, 0, 4'h0, 0, 1, 8'h78, "R6 swap");
        rd(4'h8, "R6 status count kept");
        for (int i = 0; i < 8; i++) rd(4'h0, "R3 drain");
        rd(4'h0, "R4 stale read after wrap");
        rd(4'h8, "R2 status drained");
        cyc(1, 0, 4'h0, 0, 1, 8'h99, "R6 pop on empty with push");
        rd(4'h8, "R6 status one byte");

        // R8: enable interrupt, R9 reset acknowledges
        wr(4'hC, 32'h0000_0010, "R8 enable");
        idle();
        wr(4'hC, 32'h0000_0013, "R9 rx reset");
        rd(4'h8, "R9 status cleared");
        rd(4'hC, "R9 control readback");
        // R7: transmit write strobe and readback, sets pending
        wr(4'h4, 32'hDEAD_BE5A, "R7 tx write");
        idle();
        rd(4'h4, "R7 tx readback");
        rd(4'h8, "R8 pending from tx");
        // R10: status write ignored
        wr(4'h8, 32'hFFFF_FFFF, "R10 status write");
        rd(4'h8, "R10 status unchanged");
        rd(4'hC, "R10 control unchanged");
        // R9: receive reset in the same cycle as an incoming byte
        push(8'h55, "R9 prefill");
        cyc(1, 1, 4'hC, 32'h0000_0012, 1, 8'h66, "R9 reset with push");
        rd(4'h8, "R9 status after collision");
        rd(4'h0, "R9 empty read after reset");
        // R9: bit0 has no effect
        push(8'h42, "R9 bit0");
        wr(4'hC, 32'h0000_0011, "R9 bit0 only");
        rd(4'h8, "R9 status kept with bit0");
        rd(4'h0, "R9 data kept with bit0");

        // random mix
        for (int i = 0; i < 3000; i++) begin
            logic [31:0] r = $urandom;
            logic [31:0] w = $urandom;
            bit s = r[0] | r[1];
            bit we = r[2] & r[3];
            logic [3:0] a = r[7:4];
            if (we && a[3:2] == 2'd3 && r[11:8] != 0) w[1] = 1'b0;
            cyc(s, we, a, w, r[12] | r[13], r[23:16], "random");
        end

        @(negedge clk);
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule